// File: doc/BRIEF.md
# Converter Startup and Fault Sequencer

This block is the digital supervisor of a synchronous step-down regulator. It walks the converter from power-up through a check that the power input is really present, a linear soft-start ramp, steady regulation and the handling of faults. The analog front end (comparators, error amplifier, oscillator, gate drivers) stays outside. The block reads only single-bit comparator decisions and the PWM comparator's upper-switch command. It drives a probing gate pulse, a soft-start ramp code, the resulting clamped reference code, a switching enable, a low-side conduction qualifier and a latched-off status.

The input is proven present by toggling the upper switch with short probing pulses and counting the transitions the phase-node comparator reports. Under-voltage and over-current faults share one retry counter. Each fault turns switching off for a fixed gap and then reruns the soft start. Once the retries are used up, the next fault latches the converter off. Only a new power-on reset or a shutdown pulse clears that state.

Top module: `buck_start_seq`

## Requirements
- R1: While `porFlag` is high, or the synchronised `shdnN` is low, the block sits idle with `probeGate`, `pwmEnable`, `lowSideOn` and `latchedOff` low. `rampCode` returns to 0 one cycle after the idle state is entered. `porFlag` acts on the next clock edge.
- R2: While probing, `probeGate` is high for the first `PROBE_HIGH` cycles of every `PROBE_PERIOD`-cycle window, starting with the first probing cycle. It is never high while `pwmEnable` is high.
- R3: Both rising and falling changes of the synchronised phase flag are counted during probing. The `EDGE_TARGET`-th change ends probing and starts soft start. The count restarts from zero each time probing is entered.
- R4: During soft start `rampCode` starts at 0 and rises by one code every `RAMP_STEP` cycles until it reaches all ones. The block then enters regulation and holds the ramp. `pwmEnable` is high in soft start and in regulation.
- R5: `effRef` equals the smaller of `rampCode` and `REF_CODE`.
- R6: Under-voltage flags (switcher or linear) have no effect during soft start. In regulation, a fault is taken only after either flag has been high for `UV_FILTER` consecutive synchronised cycles.
- R7: `lowSideOn` is high exactly when `pwmEnable` is high and `pwmHigh` is low. The over-current flag is acted on only while `lowSideOn` is high.
- R8: A fault (over-current, or filtered under-voltage) that does not latch drops `pwmEnable` for `HICCUP_GAP` cycles with the ramp at 0. Soft start then restarts without probing again.
- R9: Faults counted since the last clear allow `HICCUP_LIMIT` retries. The fault that arrives once `HICCUP_LIMIT` retries have been used sets `latchedOff` and keeps switching and probing off.
- R10: The latched state and the retry count clear only through `porFlag` or a low period on `shdnN`. Probing then starts again.
- R11: The comparator flags and `shdnN` each pass through two flip-flops before use. A change on `shdnN` stops switching on the third clock edge after it, and not before.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of all flops |
| porFlag | input | 1 | Synchronous power-on reset, high while the bias supply is not good |
| shdnN | input | 1 | Shutdown pin, low disables everything |
| phaseHi | input | 1 | Phase node above detection threshold (asynchronous) |
| uvSw | input | 1 | Switcher feedback below the under-voltage level (asynchronous) |
| uvLin | input | 1 | Linear channel feedback below the under-voltage level (asynchronous) |
| ocFlag | input | 1 | Low-side drop beyond the over-current level (asynchronous) |
| pwmHigh | input | 1 | Upper-switch command from the PWM comparator (synchronous) |
| probeGate | output | 1 | Probing pulse to the upper gate driver |
| rampCode | output | RAMP_W | Soft-start ramp code |
| effRef | output | RAMP_W | Reference code, lesser of ramp and fixed reference |
| pwmEnable | output | 1 | Switching allowed |
| lowSideOn | output | 1 | Low-side switch conducting, over-current sampling window |
| latchedOff | output | 1 | Converter latched off after retries ran out |

## Verification
The bench builds the block with a 20-cycle probe period, 2-cycle probe pulse, 4-bit ramp stepping every 2 cycles, reference at code 12, a 5-cycle under-voltage filter, a 6-cycle retry gap and the default retry limit of 4. With these values a whole probe, a full ramp past the clamp, a filtered fault, every retry up to the latch, and the clearing shutdown pulse all fit in a few hundred cycles. A behavioural model steps alongside and is compared on every clock. The bench also places targeted checks at the filter length, the sync latency and the retry limit.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROBE = 3'd1,
    ST_SOFT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_GAP   = 3'd4,
    ST_LATCH = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic probeRun;
    logic rampRun;
    logic rampHold;
    logic uvArm;
    logic gapRun;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic edgesDone;
    logic rampDone;
    logic uvTrip;
    logic gapDone;
    logic probeHigh;
  } dpStat_t;

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic stage1;
      logic stage2;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage1 <= 1'b0;
          stage2 <= 1'b0;
        end else begin
          stage1 <= asyncIn[i];
          stage2 <= stage1;
        end
      end
      assign syncOut[i] = stage2;
    end
  endgenerate
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int PROBE_PERIOD = 100,
  parameter int PROBE_HIGH   = 1,
  parameter int EDGE_TARGET  = 4,
  parameter int RAMP_W       = 8,
  parameter int RAMP_STEP    = 8,
  parameter int UV_FILTER    = 30,
  parameter int HICCUP_GAP   = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              phaseS,
  input  logic              uvAnyS,
  output dpStat_t           stat,
  output logic [RAMP_W-1:0] rampCode
);
  localparam int PT_W  = $clog2(PROBE_PERIOD + 1);
  localparam int EC_W  = $clog2(EDGE_TARGET + 1);
  localparam int ST_W  = $clog2(RAMP_STEP + 1);
  localparam int UV_W  = $clog2(UV_FILTER + 1);
  localparam int GP_W  = $clog2(HICCUP_GAP + 1);
  localparam logic [RAMP_W-1:0] RAMP_TOP = {RAMP_W{1'b1}};

  logic [PT_W-1:0] probeTmr;
  logic [EC_W-1:0] edgeCnt;
  logic            phPrev;
  logic [ST_W-1:0] stepTmr;
  logic [UV_W-1:0] uvCnt;
  logic [GP_W-1:0] gapTmr;
  logic            stepWrap;

  assign stepWrap = (stepTmr == ST_W'(RAMP_STEP - 1));

  // probing window timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      probeTmr <= '0;
    else if (!ctrl.probeRun)                        probeTmr <= '0;
    else if (probeTmr == PT_W'(PROBE_PERIOD - 1))   probeTmr <= '0;
    else                                            probeTmr <= probeTmr + 1'b1;
  end

  // phase transition counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phPrev  <= 1'b0;
      edgeCnt <= '0;
    end else begin
      phPrev <= phaseS;
      if (!ctrl.probeRun)
        edgeCnt <= '0;
      else if ((phaseS ^ phPrev) && !stat.edgesDone)
        edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // soft-start ramp with step prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepTmr  <= '0;
      rampCode <= '0;
    end else if (ctrl.rampRun) begin
      stepTmr <= stepWrap ? '0 : stepTmr + 1'b1;
      if (stepWrap && rampCode != RAMP_TOP)
        rampCode <= rampCode + 1'b1;
    end else if (ctrl.rampHold) begin
      stepTmr <= '0;
    end else begin
      stepTmr  <= '0;
      rampCode <= '0;
    end
  end

  // under-voltage persistence filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      uvCnt <= '0;
    else if (!ctrl.uvArm || !uvAnyS) uvCnt <= '0;
    else if (!stat.uvTrip)          uvCnt <= uvCnt + 1'b1;
  end

  // hiccup off-time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             gapTmr <= '0;
    else if (!ctrl.gapRun) gapTmr <= '0;
    else if (!stat.gapDone) gapTmr <= gapTmr + 1'b1;
  end

  assign stat.edgesDone = (edgeCnt == EC_W'(EDGE_TARGET));
  assign stat.rampDone  = (rampCode == RAMP_TOP);
  assign stat.uvTrip    = (uvCnt == UV_W'(UV_FILTER));
  assign stat.gapDone   = (gapTmr == GP_W'(HICCUP_GAP - 1));
  assign stat.probeHigh = ctrl.probeRun && (probeTmr < PT_W'(PROBE_HIGH));
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int HICCUP_LIMIT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    goOn,
  input  logic    ocHit,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    pwmEnable,
  output logic    latchedOff
);
  localparam int HC_W = $clog2(HICCUP_LIMIT + 1);

  seqState_t state, stateNxt;
  logic [HC_W-1:0] hicCnt, hicNxt;
  logic faultNow;

  always_comb begin
    stateNxt = state;
    hicNxt   = hicCnt;
    faultNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        stateNxt = ST_PROBE;
        hicNxt   = '0;
      end
      ST_PROBE: if (stat.edgesDone) stateNxt = ST_SOFT;
      ST_SOFT: begin
        if (ocHit)              faultNow = 1'b1;
        else if (stat.rampDone) stateNxt = ST_RUN;
      end
      ST_RUN:  if (ocHit || stat.uvTrip) faultNow = 1'b1;
      ST_GAP:  if (stat.gapDone) stateNxt = ST_SOFT;
      ST_LATCH: stateNxt = ST_LATCH;
      default: stateNxt = ST_IDLE;
    endcase
    if (faultNow) begin
      if (hicCnt == HC_W'(HICCUP_LIMIT)) begin
        stateNxt = ST_LATCH;
      end else begin
        stateNxt = ST_GAP;
        hicNxt   = hicCnt + 1'b1;
      end
    end
    if (!goOn) begin
      stateNxt = ST_IDLE;
      hicNxt   = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hicCnt <= '0;
    end else begin
      state  <= stateNxt;
      hicCnt <= hicNxt;
    end
  end

  assign ctrl.probeRun = (state == ST_PROBE);
  assign ctrl.rampRun  = (state == ST_SOFT);
  assign ctrl.rampHold = (state == ST_RUN);
  assign ctrl.uvArm    = (state == ST_RUN);
  assign ctrl.gapRun   = (state == ST_GAP);
  assign pwmEnable     = (state == ST_SOFT) || (state == ST_RUN);
  assign latchedOff    = (state == ST_LATCH);
endmodule

// File: rtl/buck_start_seq.sv
module buck_start_seq
  import seq_pkg::*;
#(
  parameter int PROBE_PERIOD = 100,
  parameter int PROBE_HIGH   = 1,
  parameter int EDGE_TARGET  = 4,
  parameter int RAMP_W       = 8,
  parameter int RAMP_STEP    = 8,
  parameter int REF_CODE     = 64,
  parameter int UV_FILTER    = 30,
  parameter int HICCUP_GAP   = 1000,
  parameter int HICCUP_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porFlag,
  input  logic              shdnN,
  input  logic              phaseHi,
  input  logic              uvSw,
  input  logic              uvLin,
  input  logic              ocFlag,
  input  logic              pwmHigh,
  output logic              probeGate,
  output logic [RAMP_W-1:0] rampCode,
  output logic [RAMP_W-1:0] effRef,
  output logic              pwmEnable,
  output logic              lowSideOn,
  output logic              latchedOff
);
  localparam logic [RAMP_W-1:0] REF_VAL = RAMP_W'(REF_CODE);

  logic [4:0] rawIn, syncIn;
  dpCtrl_t ctrl;
  dpStat_t stat;
  logic goOn, ocHit;

  assign rawIn = {shdnN, phaseHi, uvSw, uvLin, ocFlag};

  seq_sync #(.W(5)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  assign goOn      = !porFlag && syncIn[4];
  assign lowSideOn = pwmEnable && !pwmHigh;
  assign ocHit     = syncIn[0] && lowSideOn;

  seq_control #(.HICCUP_LIMIT(HICCUP_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .goOn(goOn), .ocHit(ocHit), .stat(stat),
    .ctrl(ctrl), .pwmEnable(pwmEnable), .latchedOff(latchedOff)
  );

  seq_datapath #(
    .PROBE_PERIOD(PROBE_PERIOD), .PROBE_HIGH(PROBE_HIGH),
    .EDGE_TARGET(EDGE_TARGET), .RAMP_W(RAMP_W), .RAMP_STEP(RAMP_STEP),
    .UV_FILTER(UV_FILTER), .HICCUP_GAP(HICCUP_GAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .phaseS(syncIn[3]),
    .uvAnyS(syncIn[2] | syncIn[1]), .stat(stat), .rampCode(rampCode)
  );

  assign probeGate = stat.probeHigh;
  assign effRef    = (rampCode < REF_VAL) ? rampCode : REF_VAL;
endmodule

// File: rtl/buck_start_seq_chk.sv
module buck_start_seq_chk #(
  parameter int RAMP_W   = 8,
  parameter int REF_CODE = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              porFlag,
  input logic              probeGate,
  input logic              pwmEnable,
  input logic              lowSideOn,
  input logic              latchedOff,
  input logic [RAMP_W-1:0] rampCode,
  input logic [RAMP_W-1:0] effRef
);
  // R1
  por_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    porFlag |=> (!pwmEnable && !probeGate && !latchedOff && !lowSideOn));

  // R2
  probe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeGate |-> !pwmEnable);

  // R4
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rampCode == $past(rampCode) || rampCode == $past(rampCode) + 1'b1
              || rampCode == '0));

  // R5
  eff_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effRef <= rampCode) && (effRef <= RAMP_W'(REF_CODE)));

  // R9
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchedOff && $past(latchedOff)) |-> (rampCode == '0 && !pwmEnable && !lowSideOn
                                          && !probeGate));
endmodule

bind buck_start_seq buck_start_seq_chk #(.RAMP_W(RAMP_W), .REF_CODE(REF_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .porFlag(porFlag), .probeGate(probeGate),
  .pwmEnable(pwmEnable), .lowSideOn(lowSideOn), .latchedOff(latchedOff),
  .rampCode(rampCode), .effRef(effRef)
);

// File: tb/buck_start_seq_bench.sv
module buck_start_seq_bench;
  localparam int PP = 20, PH = 2, ET = 4, RW = 4, RS = 2, RC = 12;
  localparam int UF = 5, HG = 6, HL = 4;
  localparam int RTOP = (1 << RW) - 1;
  localparam int S_IDLE = 0, S_PROBE = 1, S_SOFT = 2, S_RUN = 3, S_GAP = 4, S_LATCH = 5;

  logic clk = 1'b0, rstN = 1'b0, porFlag = 1'b1, shdnN = 1'b1;
  logic phaseHi = 1'b0, uvSw = 1'b0, uvLin = 1'b0, ocFlag = 1'b0, pwmHigh = 1'b1;
  logic probeGate, pwmEnable, lowSideOn, latchedOff;
  logic [RW-1:0] rampCode, effRef;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  buck_start_seq #(
    .PROBE_PERIOD(PP), .PROBE_HIGH(PH), .EDGE_TARGET(ET), .RAMP_W(RW),
    .RAMP_STEP(RS), .REF_CODE(RC), .UV_FILTER(UF), .HICCUP_GAP(HG),
    .HICCUP_LIMIT(HL)
  ) u_buck_start_seq (
    .clk(clk), .rstN(rstN), .porFlag(porFlag), .shdnN(shdnN), .phaseHi(phaseHi),
    .uvSw(uvSw), .uvLin(uvLin), .ocFlag(ocFlag), .pwmHigh(pwmHigh),
    .probeGate(probeGate), .rampCode(rampCode), .effRef(effRef),
    .pwmEnable(pwmEnable), .lowSideOn(lowSideOn), .latchedOff(latchedOff)
  );

  // behavioural reference: pipeline queues for the synchronisers, integer counters
  bit qEn[$], qPh[$], qUv[$], qOc[$];
  int mSt, mProbe, mEdge, mRamp, mStep, mUv, mGap, mHic;
  bit mPhPrev;

  task automatic model_reset();
    qEn = '{0, 0}; qPh = '{0, 0}; qUv = '{0, 0}; qOc = '{0, 0};
    mSt = S_IDLE; mProbe = 0; mEdge = 0; mRamp = 0; mStep = 0; mUv = 0; mGap = 0;
    mHic = 0; mPhPrev = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) model_reset();
    else begin
      bit go, ph, uvA, oc, fault;
      int nSt;
      go  = !porFlag && qEn[0];
      ph  = qPh[0];
      uvA = qUv[0];
      oc  = qOc[0] && (mSt == S_SOFT || mSt == S_RUN) && !pwmHigh;
      void'(qEn.pop_front()); qEn.push_back(shdnN);
      void'(qPh.pop_front()); qPh.push_back(phaseHi);
      void'(qUv.pop_front()); qUv.push_back(uvSw | uvLin);
      void'(qOc.pop_front()); qOc.push_back(ocFlag);
      nSt = mSt; fault = 0;
      case (mSt)
        S_IDLE:  begin nSt = S_PROBE; mHic = 0; end
        S_PROBE: if (mEdge == ET) nSt = S_SOFT;
        S_SOFT:  if (oc) fault = 1; else if (mRamp == RTOP) nSt = S_RUN;
        S_RUN:   if (oc || mUv == UF) fault = 1;
        S_GAP:   if (mGap == HG - 1) nSt = S_SOFT;
        default: ;
      endcase
      // counters advance on the pre-edge state
      if (mSt == S_PROBE) begin
        mProbe = (mProbe == PP - 1) ? 0 : mProbe + 1;
        if (ph != mPhPrev && mEdge != ET) mEdge++;
      end else begin mProbe = 0; mEdge = 0; end
      mPhPrev = ph;
      if (mSt == S_SOFT) begin
        if (mStep == RS - 1) begin mStep = 0; if (mRamp != RTOP) mRamp++; end
        else mStep++;
      end else if (mSt == S_RUN) mStep = 0;
      else begin mStep = 0; mRamp = 0; end
      if (mSt == S_RUN && uvA) begin if (mUv != UF) mUv++; end else mUv = 0;
      if (mSt == S_GAP) begin if (mGap != HG - 1) mGap++; end else mGap = 0;
      if (fault) begin
        if (mHic == HL) nSt = S_LATCH; else begin mHic++; nSt = S_GAP; end
      end
      if (!go) begin nSt = S_IDLE; mHic = 0; end
      mSt = nSt;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) if (rstN && !done) begin
    bit mPwm;
    mPwm = (mSt == S_SOFT || mSt == S_RUN);
    chk("R2 probeGate", probeGate, (mSt == S_PROBE) && (mProbe < PH));
    chk("R4 rampCode", rampCode, mRamp);
    chk("R5 effRef", effRef, (mRamp < RC) ? mRamp : RC);
    chk("R4 pwmEnable", pwmEnable, mPwm);
    chk("R7 lowSideOn", lowSideOn, mPwm && !pwmHigh);
    chk("R9 latchedOff", latchedOff, mSt == S_LATCH);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic togglePhase(int n);
    for (int i = 0; i < n; i++) begin phaseHi = ~phaseHi; cyc(3); end
  endtask

  task automatic ocFault();
    ocFlag = 1'b1; pwmHigh = 1'b0; cyc(4);
    ocFlag = 1'b0; pwmHigh = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    cyc(3); rstN = 1'b1; cyc(4);
    // R1: held in power-on reset
    chk("R1 idle pwm", pwmEnable, 0);
    chk("R1 idle gate", probeGate, 0);
    chk("R1 idle ramp", rampCode, 0);
    porFlag = 1'b0;
    // R2: three windows of probing, PH highs each
    cnt = 0;
    for (int i = 0; i < 3 * PP; i++) begin cyc(1); if (probeGate) cnt++; end
    chk("R2 probe highs", cnt, 3 * PH);
    // R3: fewer transitions than the target keep probing
    togglePhase(ET - 1); cyc(10);
    chk("R3 still probing", pwmEnable, 0);
    togglePhase(1); cyc(3);
    chk("R3 soft start begun", pwmEnable, 1);
    chk("R3 probing stopped", probeGate, 0);
    // R6: under-voltage ignored during soft start
    uvSw = 1'b1; cyc(10); uvSw = 1'b0;
    chk("R6 uv ignored in soft", pwmEnable, 1);
    cyc(30);
    chk("R4 ramp at top", rampCode, RTOP);
    chk("R5 ref clamped", effRef, RC);
    // R6: short under-voltage below the filter length
    uvLin = 1'b1; cyc(UF - 1); uvLin = 1'b0; cyc(10);
    chk("R6 short uv filtered", pwmEnable, 1);
    // R6/R8: long under-voltage trips a hiccup (retry 1)
    uvLin = 1'b1; cyc(10);
    chk("R6 uv fault", pwmEnable, 0);
    uvLin = 1'b0; cyc(8);
    chk("R8 restarted soft", pwmEnable, 1);
    chk("R8 ramp restarted low", rampCode <= 2, 1);
    chk("R8 no reprobe", probeGate, 0);
    cyc(40);
    // R7: over-current ignored while upper switch on
    ocFlag = 1'b1; cyc(10);
    chk("R7 oc ignored high side", pwmEnable, 1);
    pwmHigh = 1'b0; #1;
    chk("R7 lowSideOn", lowSideOn, 1);
    cyc(2);
    chk("R7 oc fault", pwmEnable, 0);
    ocFlag = 1'b0; pwmHigh = 1'b1; cyc(12);
    // retries 3 and 4
    for (int k = 0; k < HL - 2; k++) begin
      ocFault(); chk("R8 retry off", pwmEnable, 0);
      chk("R9 not latched", latchedOff, 0); cyc(12);
    end
    chk("R8 back on", pwmEnable, 1);
    ocFault(); cyc(20);
    chk("R9 latched", latchedOff, 1);
    chk("R9 off", pwmEnable, 0);
    // R10: shutdown pulse clears the latch
    shdnN = 1'b0; cyc(5);
    chk("R10 latch cleared", latchedOff, 0);
    shdnN = 1'b1;
    cnt = 0;
    for (int i = 0; i < PP; i++) begin cyc(1); if (probeGate) cnt++; end
    chk("R10 probing again", cnt > 0, 1);
    togglePhase(ET - 1); cyc(10);
    chk("R3 count restarted", pwmEnable, 0);
    togglePhase(1); cyc(6);
    chk("R3 second entry", pwmEnable, 1);
    // R11: shutdown through two synchroniser flops
    shdnN = 1'b0; cyc(2);
    chk("R11 not yet off", pwmEnable, 1);
    cyc(1);
    chk("R11 off", pwmEnable, 0);
    shdnN = 1'b1; cyc(40);
    togglePhase(ET); cyc(6);
    chk("R10 restart after shutdown", pwmEnable, 1);
    // R1: power-on reset acts on next edge
    porFlag = 1'b1; cyc(1);
    chk("R1 por off", pwmEnable, 0);
    cyc(1);
    chk("R1 por ramp", rampCode, 0);
    cyc(5);
    finish_run();
  end
endmodule